// File: doc/BRIEF.md
# Interrupt Status and Enable Bank

This block keeps the interrupt state for three interrupt lines behind a small 32-bit register port. Lines 0 and 1 each collect 32 end-of-group events, one bit per group. Line 2 collects four error events. Every line has three things: a raw pending vector that hardware events set, an enable vector, and a masked view of the pending bits. Software changes the enable vector through a pair of registers. One sets bits and the other clears bits, so no read-modify-write is needed.

Each line drives one level interrupt output, which is the OR of its masked pending bits. An end-of-interrupt register lets software drop one line for a single cycle, so that an event still pending shows up again as a fresh edge. A per-group routing register can send a group's end-of-group events to a dedicated one-cycle hardware pulse output instead of the interrupt lines. Event inputs are plain single-cycle pulses. The bus is a single valid/write/address/data port. Writes take effect on the clock edge and read data is combinational from the address.

Top module: `irq_stat_bank`

## Requirements
- R1: After reset, every pending, enable and routing bit and the end-of-interrupt register read 0, `irq_o` is 0 and `eog_pulse_o` is 0.
- R2: A hardware event sets its pending bit on the next clock edge, whether or not the event is enabled. Bit g of line 0 and line 1 is group g.
- R3: Writing the pending register of a line (line base + 0x0) sets every pending bit written as 1. Bits written as 0 keep their value.
- R4: The masked status register (line base + 0x4) reads as pending AND enable.
- R5: Writing 1s to the masked status register clears the matching pending bits, even when they are disabled. Bits written as 0 keep their value.
- R6: Writing 1s to the enable-set register (line base + 0x8) sets enable bits, and writing 1s to the enable-clear register (line base + 0xC) clears them. Both registers read back the current enable vector.
- R7: When a hardware event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Line 2 has four bits. Bit 0 is coherency error, bit 1 is trigger issued twice, bit 2 is direction interleave and bit 3 is response error from the master port. Bits 31..4 of its registers read 0, and writes to them are ignored.
- R9: `irq_o[L]` is 1 exactly when line L has at least one bit both pending and enabled.
- R10: The end-of-interrupt register at 0x20 stores bits 7..0 of the written data and reads them back. If the stored value equals a line number from 0 to 2, that line's `irq_o` is 0 in the cycle after the write and then follows R9 again. Any other value leaves every output unchanged.
- R11: The routing register at 0x74 holds one bit per group. When bit g is 1, an event for group g on line 0 or line 1 drives `eog_pulse_o[g]` high for the following cycle and sets no pending bit. When bit g is 0, that group never pulses.
- R12: The register map is end-of-interrupt at 0x20 and the routing register at 0x74. Line L has its four words at 0x24 + 16·L. Any other address reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid_i | input | 1 | Register access in this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| grp_evt_i | input | 2x32 | End-of-group event pulses, index 0 for line 0 and index 1 for line 1 |
| err_evt_i | input | 4 | Error event pulses for line 2 |
| irq_o | output | 3 | Level interrupt, one bit per line |
| eog_pulse_o | output | 32 | One-cycle end-of-group pulse per routed group |

## Verification
The hardest case to reach from the ports is a hardware event and a software clear landing on the same pending bit in the same cycle. The bench first leaves the bit pending from an earlier event, so that a clear-wins implementation would visibly drop it. It then drives the bus write and the event pulse from the same falling edge. The end-of-interrupt dip lasts only one cycle. The bench therefore samples `irq_o` on the two falling edges right after the write, with the event held pending and enabled, so both the drop and the re-assertion are seen.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   // fixed register map (byte offsets)
   localparam logic [7:0] OFS_EOI       = 8'h20;
   localparam logic [7:0] OFS_LINE_BASE = 8'h24;
   localparam logic [7:0] OFS_ROUTE     = 8'h74;
   localparam int         LINE_STRIDE   = 16;

   // word inside a line's four-word window
   typedef enum logic [1:0] {
      SUB_PEND  = 2'd0,
      SUB_MASK  = 2'd1,
      SUB_ENSET = 2'd2,
      SUB_ENCLR = 2'd3
   } line_sub_e;

   // per-line write strobes
   typedef struct packed {
      logic pend_set;
      logic pend_clr;
      logic en_set;
      logic en_clr;
   } line_wr_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int N_LINES = 3,
   localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic                          valid_i,
   input  logic                          write_i,
   input  logic [ADDR_W-1:0]             addr_i,
   output line_wr_t [N_LINES-1:0]        line_wr_o,
   output logic                          eoi_wr_o,
   output logic                          route_wr_o,
   output logic                          hit_line_o,
   output logic [IDX_W-1:0]              line_idx_o,
   output line_sub_e                     line_sub_o,
   output logic                          hit_eoi_o,
   output logic                          hit_route_o
);

   logic [ADDR_W-1:0] rel;
   logic              in_lines;
   logic              wr;

   assign wr       = valid_i & write_i;
   assign rel      = addr_i - ADDR_W'(OFS_LINE_BASE);
   assign in_lines = (addr_i >= ADDR_W'(OFS_LINE_BASE))
                   && (rel < ADDR_W'(N_LINES * LINE_STRIDE))
                   && (addr_i[1:0] == 2'b00);

   assign hit_line_o  = in_lines;
   assign line_idx_o  = IDX_W'(rel >> 4);
   assign line_sub_o  = line_sub_e'(rel[3:2]);
   assign hit_eoi_o   = (addr_i == ADDR_W'(OFS_EOI));
   assign hit_route_o = (addr_i == ADDR_W'(OFS_ROUTE));
   assign eoi_wr_o    = wr & hit_eoi_o;
   assign route_wr_o  = wr & hit_route_o;

   for (genvar l = 0; l < N_LINES; l++) begin : g_strobe
      logic sel;
      assign sel = wr & in_lines & (line_idx_o == IDX_W'(l));
      assign line_wr_o[l].pend_set = sel & (line_sub_o == SUB_PEND);
      assign line_wr_o[l].pend_clr = sel & (line_sub_o == SUB_MASK);
      assign line_wr_o[l].en_set   = sel & (line_sub_o == SUB_ENSET);
      assign line_wr_o[l].en_clr   = sel & (line_sub_o == SUB_ENCLR);
   end

endmodule

// File: rtl/irq_line.sv
module irq_line
   import irq_bank_pkg::*;
#(
   parameter int N_EVT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] hw_evt_i,
   input  line_wr_t         wr_i,
   input  logic [N_EVT-1:0] wdata_i,
   input  logic             eoi_hit_i,
   output logic [N_EVT-1:0] pend_o,
   output logic [N_EVT-1:0] en_o,
   output logic             irq_o
);

   logic [N_EVT-1:0] pend_q, pend_d;
   logic [N_EVT-1:0] en_q, en_d;
   logic             blank_q;

   always_comb begin
      // software clear first, then hardware and software sets win
      pend_d = pend_q;
      if (wr_i.pend_clr) pend_d = pend_d & ~wdata_i;
      pend_d = pend_d | hw_evt_i;
      if (wr_i.pend_set) pend_d = pend_d | wdata_i;

      en_d = en_q;
      if (wr_i.en_set) en_d = en_d | wdata_i;
      if (wr_i.en_clr) en_d = en_d & ~wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         en_q    <= '0;
         blank_q <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         en_q    <= en_d;
         blank_q <= eoi_hit_i;
      end
   end

   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign irq_o  = (|(pend_q & en_q)) & ~blank_q;

endmodule

// File: rtl/irq_pulse_route.sv
module irq_pulse_route #(
   parameter int GRP_CNT = 32,
   parameter int N_SRC   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sel_wr_i,
   input  logic [GRP_CNT-1:0]            sel_wdata_i,
   input  logic [N_SRC-1:0][GRP_CNT-1:0] src_evt_i,
   output logic [GRP_CNT-1:0]            sel_o,
   output logic [N_SRC-1:0][GRP_CNT-1:0] irq_evt_o,
   output logic [GRP_CNT-1:0]            pulse_o
);

   logic [GRP_CNT-1:0] sel_q;
   logic [GRP_CNT-1:0] pulse_q;
   logic [GRP_CNT-1:0] any_evt;

   always_comb begin
      any_evt = '0;
      for (int s = 0; s < N_SRC; s++) any_evt = any_evt | src_evt_i[s];
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_mask
      assign irq_evt_o[s] = src_evt_i[s] & ~sel_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         pulse_q <= '0;
      end else begin
         if (sel_wr_i) sel_q <= sel_wdata_i;
         pulse_q <= any_evt & sel_q;
      end
   end

   assign sel_o   = sel_q;
   assign pulse_o = pulse_q;

endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int GRP_CNT     = 32,
   parameter int N_GRP_LINES = 2,
   parameter int ERR_CNT     = 4,
   parameter int EOI_W       = 8,
   localparam int N_LINES    = N_GRP_LINES + 1,
   localparam int IDX_W      = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_valid_i,
   input  logic                                reg_write_i,
   input  logic [ADDR_W-1:0]                   reg_addr_i,
   input  logic [DATA_W-1:0]                   reg_wdata_i,
   output logic [DATA_W-1:0]                   reg_rdata_o,
   input  logic [N_GRP_LINES-1:0][GRP_CNT-1:0] grp_evt_i,
   input  logic [ERR_CNT-1:0]                  err_evt_i,
   output logic [N_LINES-1:0]                  irq_o,
   output logic [GRP_CNT-1:0]                  eog_pulse_o
);

   // elaboration-time configuration checks
   if (GRP_CNT < 1 || GRP_CNT > DATA_W) begin : g_bad_grp
      $error("GRP_CNT must be in 1..DATA_W");
   end
   if (ERR_CNT < 1 || ERR_CNT > DATA_W) begin : g_bad_err
      $error("ERR_CNT must be in 1..DATA_W");
   end
   if (EOI_W < 2 || EOI_W > DATA_W) begin : g_bad_eoi
      $error("EOI_W must be in 2..DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (int'(OFS_LINE_BASE) + N_LINES * LINE_STRIDE > int'(OFS_ROUTE)) begin : g_bad_map
      $error("line windows overlap the routing register");
   end

   line_wr_t [N_LINES-1:0]              line_wr;
   logic                                eoi_wr, route_wr;
   logic                                hit_line, hit_eoi, hit_route;
   logic [IDX_W-1:0]                    line_idx;
   line_sub_e                           line_sub;

   logic [EOI_W-1:0]                    eoi_q;
   logic [GRP_CNT-1:0]                  route_sel;
   logic [N_GRP_LINES-1:0][GRP_CNT-1:0] grp_irq_evt;
   logic [N_LINES-1:0][DATA_W-1:0]      pend_all;
   logic [N_LINES-1:0][DATA_W-1:0]      en_all;

   irq_reg_decode #(
      .ADDR_W  (ADDR_W),
      .N_LINES (N_LINES)
   ) u_dec (
      .valid_i     (reg_valid_i),
      .write_i     (reg_write_i),
      .addr_i      (reg_addr_i),
      .line_wr_o   (line_wr),
      .eoi_wr_o    (eoi_wr),
      .route_wr_o  (route_wr),
      .hit_line_o  (hit_line),
      .line_idx_o  (line_idx),
      .line_sub_o  (line_sub),
      .hit_eoi_o   (hit_eoi),
      .hit_route_o (hit_route)
   );

   irq_pulse_route #(
      .GRP_CNT (GRP_CNT),
      .N_SRC   (N_GRP_LINES)
   ) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_wr_i    (route_wr),
      .sel_wdata_i (reg_wdata_i[GRP_CNT-1:0]),
      .src_evt_i   (grp_evt_i),
      .sel_o       (route_sel),
      .irq_evt_o   (grp_irq_evt),
      .pulse_o     (eog_pulse_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      eoi_q <= '0;
      else if (eoi_wr) eoi_q <= reg_wdata_i[EOI_W-1:0];
   end

   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      localparam int W = (l < N_GRP_LINES) ? GRP_CNT : ERR_CNT;
      logic [W-1:0] evt, pend, en;
      logic         hit;

      if (l < N_GRP_LINES) begin : g_grp
         assign evt = grp_irq_evt[l];
      end else begin : g_err
         assign evt = err_evt_i;
      end

      assign hit = eoi_wr && (reg_wdata_i[EOI_W-1:0] == EOI_W'(l));

      irq_line #(.N_EVT(W)) u_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .hw_evt_i  (evt),
         .wr_i      (line_wr[l]),
         .wdata_i   (reg_wdata_i[W-1:0]),
         .eoi_hit_i (hit),
         .pend_o    (pend),
         .en_o      (en),
         .irq_o     (irq_o[l])
      );

      assign pend_all[l][W-1:0] = pend;
      assign en_all[l][W-1:0]   = en;
      if (W < DATA_W) begin : g_pad
         assign pend_all[l][DATA_W-1:W] = '0;
         assign en_all[l][DATA_W-1:W]   = '0;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      if (hit_eoi) begin
         reg_rdata_o[EOI_W-1:0] = eoi_q;
      end else if (hit_route) begin
         reg_rdata_o[GRP_CNT-1:0] = route_sel;
      end else if (hit_line) begin
         unique case (line_sub)
            SUB_PEND:  reg_rdata_o = pend_all[line_idx];
            SUB_MASK:  reg_rdata_o = pend_all[line_idx] & en_all[line_idx];
            default:   reg_rdata_o = en_all[line_idx];
         endcase
      end
   end

endmodule

// File: rtl/irq_stat_bank_chk.sv
module irq_stat_bank_chk
   import irq_bank_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int GRP_CNT     = 32,
   parameter int N_GRP_LINES = 2,
   parameter int EOI_W       = 8,
   localparam int N_LINES    = N_GRP_LINES + 1
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                reg_valid_i,
   input logic                                reg_write_i,
   input logic [ADDR_W-1:0]                   reg_addr_i,
   input logic [DATA_W-1:0]                   reg_wdata_i,
   input logic [N_GRP_LINES-1:0][GRP_CNT-1:0] grp_evt_i,
   input logic [N_LINES-1:0]                  irq_o,
   input logic [GRP_CNT-1:0]                  eog_pulse_o,
   input logic [GRP_CNT-1:0]                  route_sel,
   input logic [N_LINES-1:0][DATA_W-1:0]      pend_all,
   input logic [N_LINES-1:0][DATA_W-1:0]      en_all
);

   logic [GRP_CNT-1:0] any_grp;
   always_comb begin
      any_grp = '0;
      for (int s = 0; s < N_GRP_LINES; s++) any_grp = any_grp | grp_evt_i[s];
   end

   // R2
   pend_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |->
      ((pend_all[0][GRP_CNT-1:0] & $past(grp_evt_i[0] & ~route_sel))
        == $past(grp_evt_i[0] & ~route_sel)));

   // R11
   pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((eog_pulse_o & ~$past(any_grp & route_sel)) == '0));

   // R6
   en_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid_i && reg_write_i
       && reg_addr_i == ADDR_W'(OFS_LINE_BASE + 8'h08))
      |=> ((en_all[0][GRP_CNT-1:0] & $past(reg_wdata_i[GRP_CNT-1:0]))
            == $past(reg_wdata_i[GRP_CNT-1:0])));

   for (genvar l = 0; l < N_LINES; l++) begin : g_line_chk
      // R10
      eoi_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_valid_i && reg_write_i && reg_addr_i == ADDR_W'(OFS_EOI)
          && reg_wdata_i[EOI_W-1:0] == EOI_W'(l))
         |=> !irq_o[l]);

      // R9
      irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[l] |-> (|(pend_all[l] & en_all[l])));
   end

endmodule

bind irq_stat_bank irq_stat_bank_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .GRP_CNT     (GRP_CNT),
   .N_GRP_LINES (N_GRP_LINES),
   .EOI_W       (EOI_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_valid_i (reg_valid_i),
   .reg_write_i (reg_write_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .grp_evt_i   (grp_evt_i),
   .irq_o       (irq_o),
   .eog_pulse_o (eog_pulse_o),
   .route_sel   (route_sel),
   .pend_all    (pend_all),
   .en_all      (en_all)
);

// File: tb/irq_stat_bank_bench.sv
module irq_stat_bank_bench;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_valid = 1'b0;
   logic             reg_write = 1'b0;
   logic [7:0]       reg_addr = '0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [1:0][31:0] grp_evt = '0;
   logic [3:0]       err_evt = '0;
   logic [2:0]       irq;
   logic [31:0]      eog_pulse;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_stat_bank u_irq_stat_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_valid_i (reg_valid),
      .reg_write_i (reg_write),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .grp_evt_i   (grp_evt),
      .err_evt_i   (err_evt),
      .irq_o       (irq),
      .eog_pulse_o (eog_pulse)
   );

   // {write, addr, data or expected, requirement number}
   localparam int NV = 34;
   localparam logic [48:0] VEC [NV] = '{
      {1'b1, 8'h24, 32'h0000_00F0, 8'd3},  // R3 set pending bits
      {1'b0, 8'h24, 32'h0000_00F0, 8'd3},
      {1'b1, 8'h24, 32'h0000_0000, 8'd3},  // R3 zeros do nothing
      {1'b0, 8'h24, 32'h0000_00F0, 8'd3},
      {1'b1, 8'h2C, 32'h0000_0030, 8'd6},  // R6 enable set
      {1'b0, 8'h2C, 32'h0000_0030, 8'd6},
      {1'b0, 8'h30, 32'h0000_0030, 8'd6},
      {1'b1, 8'h30, 32'h0000_0010, 8'd6},  // R6 enable clear
      {1'b0, 8'h2C, 32'h0000_0020, 8'd6},
      {1'b0, 8'h30, 32'h0000_0020, 8'd6},
      {1'b0, 8'h28, 32'h0000_0020, 8'd4},  // R4 masked view
      {1'b1, 8'h28, 32'h0000_0090, 8'd5},  // R5 clears bit 7 while disabled
      {1'b0, 8'h24, 32'h0000_0060, 8'd5},
      {1'b0, 8'h28, 32'h0000_0020, 8'd4},
      {1'b1, 8'h28, 32'h0000_0020, 8'd5},
      {1'b0, 8'h24, 32'h0000_0040, 8'd5},
      {1'b0, 8'h28, 32'h0000_0000, 8'd4},
      {1'b1, 8'h44, 32'hFFFF_FFFF, 8'd8},  // R8 four error bits only
      {1'b0, 8'h44, 32'h0000_000F, 8'd8},
      {1'b1, 8'h4C, 32'hFFFF_FFF0, 8'd8},
      {1'b0, 8'h4C, 32'h0000_0000, 8'd8},
      {1'b1, 8'h78, 32'hFFFF_FFFF, 8'd12}, // R12 unmapped
      {1'b0, 8'h78, 32'h0000_0000, 8'd12},
      {1'b0, 8'h10, 32'h0000_0000, 8'd12},
      {1'b1, 8'h74, 32'h8000_0001, 8'd11}, // R11 routing register
      {1'b0, 8'h74, 32'h8000_0001, 8'd11},
      {1'b1, 8'h20, 32'h1234_56AB, 8'd10}, // R10 stores low byte
      {1'b0, 8'h20, 32'h0000_00AB, 8'd10},
      {1'b1, 8'h28, 32'hFFFF_FFFF, 8'd5},
      {1'b1, 8'h30, 32'hFFFF_FFFF, 8'd6},
      {1'b1, 8'h74, 32'h0000_0000, 8'd11},
      {1'b1, 8'h48, 32'h0000_000F, 8'd5},
      {1'b0, 8'h24, 32'h0000_0000, 8'd5},
      {1'b0, 8'h44, 32'h0000_0000, 8'd5}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic bus_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      #1 chk(tag, reg_rdata, exp);
      reg_valid = 1'b0;
   endtask

   // one-cycle event; checks the pulse output in the cycle after
   task automatic ev(input int ln, input logic [31:0] m, input logic [31:0] exp_pulse);
      @(negedge clk);
      if (ln < 2) grp_evt[ln] = m;
      else        err_evt = m[3:0];
      @(negedge clk);
      grp_evt = '0; err_evt = '0;
      #1 chk("R11 pulse", eog_pulse, exp_pulse);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1 chk("R1 irq", {29'd0, irq}, 32'd0);
      chk("R1 pulse", eog_pulse, 32'd0);
      bus_rd("R1 pend0", 8'h24, 32'd0);
      bus_rd("R1 en1", 8'h3C, 32'd0);
      bus_rd("R1 route", 8'h74, 32'd0);
      bus_rd("R1 eoi", 8'h20, 32'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [48:0] v;
         string       t;
         v = VEC[i];
         t = $sformatf("R%0d vec%0d", v[7:0], i);
         if (v[48]) bus_wr(v[47:40], v[39:8]);
         else       bus_rd(t, v[47:40], v[39:8]);
      end

      // R2 events set pending regardless of enable
      ev(0, 32'h0000_0008, 32'd0);
      bus_rd("R2 line0", 8'h24, 32'h0000_0008);
      ev(1, 32'h8000_0000, 32'd0);
      bus_rd("R2 line1", 8'h34, 32'h8000_0000);
      ev(2, 32'h0000_0004, 32'd0);
      bus_rd("R8 direction interleave bit2", 8'h44, 32'h0000_0004);
      bus_rd("R4 disabled masked", 8'h28, 32'd0);

      // R7 event and clear in the same cycle
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h8;
      grp_evt[0] = 32'h8;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0; grp_evt = '0;
      bus_rd("R7 event wins", 8'h24, 32'h0000_0008);
      bus_wr(8'h28, 32'h8);
      bus_rd("R5 cleared", 8'h24, 32'd0);

      // R9 interrupt level
      #1 chk("R9 idle", {29'd0, irq}, 32'd0);
      bus_wr(8'h3C, 32'h8000_0000);
      #1 chk("R9 line1 up", {29'd0, irq}, 32'h2);

      // R10 end-of-interrupt dip on line 1
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h1;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
      #1 chk("R10 dip", {29'd0, irq}, 32'h0);
      @(negedge clk);
      #1 chk("R10 reassert", {29'd0, irq}, 32'h2);
      bus_wr(8'h20, 32'h5);
      #1 chk("R10 other value", {29'd0, irq}, 32'h2);
      @(negedge clk);
      #1 chk("R10 other value next", {29'd0, irq}, 32'h2);
      bus_wr(8'h38, 32'h8000_0000);
      #1 chk("R9 cleared", {29'd0, irq}, 32'h0);

      // R9 line 2 uses the pending direction-interleave bit
      bus_wr(8'h4C, 32'h4);
      #1 chk("R9 line2 up", {29'd0, irq}, 32'h4);
      bus_rd("R4 line2 masked", 8'h48, 32'h4);
      bus_wr(8'h48, 32'h4);
      #1 chk("R9 line2 down", {29'd0, irq}, 32'h0);

      // R11 pulse routing
      bus_wr(8'h74, 32'h4);
      ev(0, 32'h4, 32'h4);
      @(negedge clk);
      #1 chk("R11 one cycle", eog_pulse, 32'd0);
      bus_rd("R11 no pending line0", 8'h24, 32'd0);
      ev(1, 32'h4, 32'h4);
      bus_rd("R11 no pending line1", 8'h34, 32'd0);
      ev(0, 32'h8, 32'd0);
      bus_rd("R11 unrouted sets", 8'h24, 32'h8);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule